// File: doc/BRIEF.md
# Segment Descriptor Load Unit

This block services requests to load a 16-bit selector into one of six segment registers. The selector is a byte offset into a descriptor table in memory. The table's location and length come from a table register that a separate strobe writes. On each request the unit first screens the selector against the null entry and the table length. It then fetches the 8-byte descriptor as two 32-bit reads and screens the descriptor's present, reserved and class bits. A descriptor that passes is decoded into base, limit and attributes and stored in the target register's hidden cache. If the descriptor's accessed flag was clear, the unit first writes that flag back to the table. Every request ends with a one-cycle completion pulse or a one-cycle fault pulse that carries a cause code. A read port shows the contents of any cache.

The control is a state machine with seven states.

- IDLE is the only state that accepts a request. It moves to FAULT when the selector is null or out of bounds, and to FETCH_LO otherwise.
- FETCH_LO moves to FETCH_HI on the memory acknowledge.
- FETCH_HI moves to VET on the memory acknowledge.
- VET moves to FAULT on a descriptor error, to DONE when the accessed flag is already set, and to MARK when it is clear.
- MARK moves to DONE on the acknowledge of the flag write.
- DONE and FAULT each last one cycle and return to IDLE.

Top module: `segld_top`

## Requirements
- R1: After reset the unit is ready, asserts no pulse and no memory request, and every cache reads back as all zeros.
- R2: The descriptor address is the table base plus the selector. The unit reads the word at that address first and the word at that address plus 4 second. It holds each request, its address and its direction steady until `mem_ack`.
- R3: A selector of 0 faults with cause 0 in the cycle after acceptance, with no memory access.
- R4: A selector faults with cause 1 in the cycle after acceptance, with no memory access, when selector + 7 exceeds the table size field. That field holds the table length minus one. The check uses the table register as it stood before any table write on the same clock edge.
- R5: A descriptor whose present bit is clear faults with cause 2. The present bit is bit 7 of the access byte, which is descriptor bits 47:40.
- R6: A descriptor faults with cause 4 in either of two cases: access-byte bit 4 is 0, or either of flag bits 0 and 1 (descriptor bits 52 and 53) is 1. A missing present bit takes priority over this error, and this error takes priority over a class error.
- R7: Access-byte bit 3 marks a code descriptor, which loads only into register 0 (the code register). A data descriptor loads only into registers 1 to 5. Any other pairing, including register index 6 or 7, faults with cause 3.
- R8: A successful load stores four values in the target cache: the selector; the base, taken from descriptor bits 63:56, 39:16; the limit; and a 12-bit attribute, made of the flag nibble above the access byte with bit 0 set. The limit is the 20-bit field (descriptor bits 51:48, 15:0). It is extended with 12 one bits at the bottom when flag bit 3 (descriptor bit 55) is set, and zero-extended otherwise. The done pulse comes in the cycle after the cache update.
- R9: When access-byte bit 0 was 0, the unit makes exactly one write before completing. The write goes to the descriptor address plus 4 with byte enable 4'b0010, and carries the high word with bit 8 set. When that bit was already 1, the unit makes no write.
- R10: With no memory wait states, the pulse appears 1 cycle after the accept edge for a selector fault, 4 cycles for a descriptor fault or a load without write-back, and 5 cycles for a load with write-back. Done and fault each last one cycle and never coincide.
- R11: Ready is low from the accept edge through the pulse, and high again in the following cycle. A fault leaves every cache unchanged.
- R12: `rd_idx` selects the cache shown on the read port. An index of 6 or 7 reads all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_wr | input | 1 | Table register write strobe |
| tbl_base | input | 32 | New table base address |
| tbl_size | input | 16 | New table size field (length minus one) |
| req_valid | input | 1 | Load request |
| req_ready | output | 1 | Unit idle and able to accept |
| req_sel | input | 16 | Selector (byte offset into the table) |
| req_idx | input | 3 | Target register index, 0 = code register |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | One-cycle fault pulse |
| fault_cause | output | 3 | Cause code, valid with `fault` |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the access |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completes on this edge |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| rd_idx | input | 3 | Cache read select |
| rd_sel | output | 16 | Selected cache: selector |
| rd_base | output | 32 | Selected cache: base |
| rd_limit | output | 32 | Selected cache: effective limit |
| rd_attr | output | 12 | Selected cache: flags and access byte |

## Verification
A table-register write and the acceptance of a load request can land on the same clock edge. The bench provokes this with a selector that is out of bounds under the old size but in bounds under the new one. Asserting the strobe and the request together, it expects a bound fault with no memory traffic. An immediate repeat of the same request must then complete with a write-back. The bench model applies the new size only after the accepting edge, so a unit that checks against the freshly written value shows up as a miscompare on the cause and on the read-address log.

// File: rtl/segld_pkg.sv
package segld_pkg;
    localparam int DESC_BYTES = 8;
    localparam int SEL_W      = 16;
    localparam int TSIZE_W    = 16;
    localparam int ADDR_W     = 32;
    localparam int DATA_W     = 32;
    localparam int LIM_W      = 20;
    localparam int ATTR_W     = 12;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_LO,
        ST_FETCH_HI,
        ST_VET,
        ST_MARK,
        ST_DONE,
        ST_FAULT
    } ld_state_e;

    typedef enum logic [2:0] {
        FC_NULL   = 3'd0,
        FC_BOUND  = 3'd1,
        FC_ABSENT = 3'd2,
        FC_CLASS  = 3'd3,
        FC_RSVD   = 3'd4
    } fault_e;

    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] limit;
        logic [ATTR_W-1:0] attr;
    } seg_cache_t;
endpackage

// File: rtl/segld_tbl.sv
module segld_tbl
    import segld_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] base_in,
    input  logic [TSIZE_W-1:0] size_in,
    input  logic [SEL_W-1:0]  sel,
    output logic [ADDR_W-1:0] desc_addr,
    output logic              null_hit,
    output logic              bound_miss
);
    localparam int SPAN_W = ((SEL_W > TSIZE_W) ? SEL_W : TSIZE_W) + 1;

    logic [ADDR_W-1:0]  base_q;
    logic [TSIZE_W-1:0] size_q;
    logic [SPAN_W-1:0]  last_byte;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            size_q <= '0;
        end else if (wr_en) begin
            base_q <= base_in;
            size_q <= size_in;
        end
    end

    // Inclusive last byte of the requested descriptor, one bit wider to avoid wrap.
    assign last_byte  = SPAN_W'(sel) + SPAN_W'(DESC_BYTES - 1);
    assign bound_miss = last_byte > SPAN_W'(size_q);
    assign null_hit   = (sel == '0);
    assign desc_addr  = base_q + ADDR_W'(sel);
endmodule

// File: rtl/segld_decode.sv
module segld_decode
    import segld_pkg::*;
#(
    parameter  int NUM_SEG  = 6,
    parameter  int CODE_IDX = 0,
    localparam int IDX_W    = $clog2(NUM_SEG)
) (
    input  logic [DATA_W-1:0] lo,
    input  logic [DATA_W-1:0] hi,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] limit,
    output logic [ATTR_W-1:0] attr,
    output logic              already_acc,
    output logic              bad,
    output fault_e            cause
);
    logic [7:0]       acc;
    logic [3:0]       flg;
    logic [LIM_W-1:0] lim;
    logic             is_code;
    logic             class_ok;
    logic             rsvd_bad;

    assign acc  = hi[15:8];
    assign flg  = hi[23:20];
    assign lim  = {hi[19:16], lo[15:0]};
    assign base = {hi[31:24], hi[7:0], lo[31:16]};

    assign limit = flg[3] ? {lim, {(ADDR_W-LIM_W){1'b1}}}
                          : {{(ADDR_W-LIM_W){1'b0}}, lim};
    assign attr  = {flg, acc[7:1], 1'b1};

    assign already_acc = acc[0];
    assign is_code     = acc[3];
    assign rsvd_bad    = !acc[4] || flg[0] || flg[1];
    assign class_ok    = is_code ? (int'(idx) == CODE_IDX)
                                 : ((int'(idx) != CODE_IDX) && (int'(idx) < NUM_SEG));

    always_comb begin
        bad   = 1'b1;
        cause = FC_ABSENT;
        if (!acc[7]) begin
            cause = FC_ABSENT;
        end else if (rsvd_bad) begin
            cause = FC_RSVD;
        end else if (!class_ok) begin
            cause = FC_CLASS;
        end else begin
            bad = 1'b0;
        end
    end
endmodule

// File: rtl/segld_cache.sv
module segld_cache
    import segld_pkg::*;
#(
    parameter  int NUM_SEG = 6,
    localparam int IDX_W   = $clog2(NUM_SEG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  seg_cache_t       wr_entry,
    input  logic [IDX_W-1:0] rd_idx,
    output seg_cache_t       rd_entry
);
    seg_cache_t [NUM_SEG-1:0] regs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NUM_SEG; i++) begin
                if (int'(wr_idx) == i) regs_q[i] <= wr_entry;
            end
        end
    end

    always_comb begin
        rd_entry = '0;
        for (int i = 0; i < NUM_SEG; i++) begin
            if (int'(rd_idx) == i) rd_entry = regs_q[i];
        end
    end
endmodule

// File: rtl/segld_fsm.sv
module segld_fsm
    import segld_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic null_hit,
    input  logic bound_miss,
    input  logic mem_ack,
    input  logic vet_bad,
    input  logic already_acc,
    output logic accept,
    output logic take_lo,
    output logic take_hi,
    output logic vet_fault,
    output logic commit,
    output logic ready,
    output logic mem_req,
    output logic mem_we,
    output logic lo_phase,
    output logic done,
    output logic fault
);
    ld_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:     if (req_valid) st_d = (null_hit || bound_miss) ? ST_FAULT : ST_FETCH_LO;
            ST_FETCH_LO: if (mem_ack) st_d = ST_FETCH_HI;
            ST_FETCH_HI: if (mem_ack) st_d = ST_VET;
            ST_VET:      st_d = vet_bad ? ST_FAULT : (already_acc ? ST_DONE : ST_MARK);
            ST_MARK:     if (mem_ack) st_d = ST_DONE;
            ST_DONE:     st_d = ST_IDLE;
            ST_FAULT:    st_d = ST_IDLE;
            default:     st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        accept    = 1'b0;
        take_lo   = 1'b0;
        take_hi   = 1'b0;
        vet_fault = 1'b0;
        commit    = 1'b0;
        ready     = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        lo_phase  = 1'b0;
        done      = 1'b0;
        fault     = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                ready  = 1'b1;
                accept = req_valid;
            end
            ST_FETCH_LO: begin
                mem_req  = 1'b1;
                lo_phase = 1'b1;
                take_lo  = mem_ack;
            end
            ST_FETCH_HI: begin
                mem_req = 1'b1;
                take_hi = mem_ack;
            end
            ST_VET: begin
                vet_fault = vet_bad;
                commit    = !vet_bad && already_acc;
            end
            ST_MARK: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                commit  = mem_ack;
            end
            ST_DONE:  done  = 1'b1;
            ST_FAULT: fault = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/segld_top.sv
module segld_top
    import segld_pkg::*;
#(
    parameter  int NUM_SEG  = 6,
    parameter  int CODE_IDX = 0,
    localparam int IDX_W    = $clog2(NUM_SEG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tbl_wr,
    input  logic [ADDR_W-1:0]  tbl_base,
    input  logic [TSIZE_W-1:0] tbl_size,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [SEL_W-1:0]   req_sel,
    input  logic [IDX_W-1:0]   req_idx,
    output logic               done,
    output logic               fault,
    output logic [2:0]         fault_cause,
    output logic               mem_req,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [3:0]         mem_be,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic               mem_ack,
    input  logic [DATA_W-1:0]  mem_rdata,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [SEL_W-1:0]   rd_sel,
    output logic [ADDR_W-1:0]  rd_base,
    output logic [ADDR_W-1:0]  rd_limit,
    output logic [ATTR_W-1:0]  rd_attr
);
    logic [ADDR_W-1:0] desc_addr;
    logic              null_hit, bound_miss;
    logic              accept, take_lo, take_hi, vet_fault, commit, lo_phase;
    logic              vet_bad, already_acc;
    fault_e            vet_cause;
    logic [ADDR_W-1:0] dec_base, dec_limit;
    logic [ATTR_W-1:0] dec_attr;
    seg_cache_t        new_entry, shown;

    logic [SEL_W-1:0]  sel_q;
    logic [IDX_W-1:0]  idx_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] lo_q, hi_q;
    fault_e            cause_q;

    segld_tbl u_tbl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (tbl_wr),
        .base_in    (tbl_base),
        .size_in    (tbl_size),
        .sel        (req_sel),
        .desc_addr  (desc_addr),
        .null_hit   (null_hit),
        .bound_miss (bound_miss)
    );

    segld_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .null_hit    (null_hit),
        .bound_miss  (bound_miss),
        .mem_ack     (mem_ack),
        .vet_bad     (vet_bad),
        .already_acc (already_acc),
        .accept      (accept),
        .take_lo     (take_lo),
        .take_hi     (take_hi),
        .vet_fault   (vet_fault),
        .commit      (commit),
        .ready       (req_ready),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .lo_phase    (lo_phase),
        .done        (done),
        .fault       (fault)
    );

    segld_decode #(.NUM_SEG(NUM_SEG), .CODE_IDX(CODE_IDX)) u_dec (
        .lo          (lo_q),
        .hi          (hi_q),
        .idx         (idx_q),
        .base        (dec_base),
        .limit       (dec_limit),
        .attr        (dec_attr),
        .already_acc (already_acc),
        .bad         (vet_bad),
        .cause       (vet_cause)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q   <= '0;
            idx_q   <= '0;
            addr_q  <= '0;
            lo_q    <= '0;
            hi_q    <= '0;
            cause_q <= FC_NULL;
        end else begin
            if (accept) begin
                sel_q   <= req_sel;
                idx_q   <= req_idx;
                addr_q  <= desc_addr;
                cause_q <= null_hit ? FC_NULL : FC_BOUND;
            end
            if (take_lo)   lo_q    <= mem_rdata;
            if (take_hi)   hi_q    <= mem_rdata;
            if (vet_fault) cause_q <= vet_cause;
        end
    end

    assign new_entry = '{sel: sel_q, base: dec_base, limit: dec_limit, attr: dec_attr};

    segld_cache #(.NUM_SEG(NUM_SEG)) u_cache (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (commit),
        .wr_idx   (idx_q),
        .wr_entry (new_entry),
        .rd_idx   (rd_idx),
        .rd_entry (shown)
    );

    assign mem_addr    = lo_phase ? addr_q : addr_q + ADDR_W'(4);
    assign mem_be      = mem_we ? 4'b0010 : 4'b1111;
    assign mem_wdata   = {hi_q[31:9], 1'b1, hi_q[7:0]};
    assign fault_cause = fault ? 3'(cause_q) : 3'd0;

    assign rd_sel   = shown.sel;
    assign rd_base  = shown.base;
    assign rd_limit = shown.limit;
    assign rd_attr  = shown.attr;
endmodule

// File: rtl/segld_chk.sv
module segld_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [15:0] req_sel,
    input logic        done,
    input logic        fault,
    input logic [2:0]  fault_cause,
    input logic        mem_req,
    input logic        mem_we,
    input logic        mem_ack,
    input logic [31:0] mem_addr,
    input logic [3:0]  mem_be,
    input logic [31:0] mem_wdata
);
    assert_pulse_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_fault_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !fault);

    assert_null_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_sel == 16'h0) |=> (fault && fault_cause == 3'd0));

    assert_hold_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    assert_mark_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_be == 4'b0010 && mem_wdata[8]));

    assert_busy_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fault) |-> !req_ready);

    assert_ready_after_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fault) |=> req_ready);

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req);
endmodule

bind segld_top segld_chk u_segld_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_sel     (req_sel),
    .done        (done),
    .fault       (fault),
    .fault_cause (fault_cause),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_ack     (mem_ack),
    .mem_addr    (mem_addr),
    .mem_be      (mem_be),
    .mem_wdata   (mem_wdata)
);

// File: tb/test_segld_top.sv
`timescale 1ns/1ps
module test_segld_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        tbl_wr;
    logic [31:0] tbl_base;
    logic [15:0] tbl_size;
    logic        req_valid;
    logic        req_ready;
    logic [15:0] req_sel;
    logic [2:0]  req_idx;
    logic        done, fault;
    logic [2:0]  fault_cause;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0]  mem_be;
    logic [2:0]  rd_idx;
    logic [15:0] rd_sel;
    logic [31:0] rd_base, rd_limit;
    logic [11:0] rd_attr;

    always #4 clk = ~clk;

    segld_top i_segld_top (
        .clk(clk), .rst_n(rst_n), .tbl_wr(tbl_wr), .tbl_base(tbl_base), .tbl_size(tbl_size),
        .req_valid(req_valid), .req_ready(req_ready), .req_sel(req_sel), .req_idx(req_idx),
        .done(done), .fault(fault), .fault_cause(fault_cause),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .rd_idx(rd_idx), .rd_sel(rd_sel), .rd_base(rd_base), .rd_limit(rd_limit), .rd_attr(rd_attr)
    );

    // Behavioural memory, byte array with a single writer process.
    logic [7:0]  mem [0:1023];
    logic [9:0]  ma;
    logic        tb_we;
    logic [9:0]  tb_wa;
    logic [7:0]  tb_wd;
    int          rd_cnt = 0, wr_cnt = 0;
    logic [31:0] rd_log [4];
    logic [31:0] wr_log;
    logic        stall = 1'b0;
    bit          stall_en = 1'b0;
    int          cyc = 0;

    assign ma        = mem_addr[9:0];
    assign mem_rdata = {mem[ma + 10'd3], mem[ma + 10'd2], mem[ma + 10'd1], mem[ma]};
    assign mem_ack   = mem_req && !stall;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 1024; i++) mem[i] <= 8'h00;
        end else begin
            if (tb_we) mem[tb_wa] <= tb_wd;
            if (mem_req && mem_ack) begin
                if (mem_we) begin
                    for (int b = 0; b < 4; b++)
                        if (mem_be[b]) mem[ma + 10'(b)] <= mem_wdata[8*b +: 8];
                    wr_log = mem_addr;
                    wr_cnt++;
                end else begin
                    rd_log[rd_cnt % 4] = mem_addr;
                    rd_cnt++;
                end
            end
        end
    end

    always @(negedge clk) begin
        cyc++;
        stall <= stall_en && (cyc % 3 != 0);
    end

    int vectors = 0, miscompares = 0;
    logic [31:0] tbase_m;
    logic [15:0] tsize_m;
    logic [15:0] e_sel  [8];
    logic [31:0] e_base [8];
    logic [31:0] e_lim  [8];
    logic [11:0] e_attr [8];

    task automatic check_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL R10 watchdog actual=hung expected=finished");
        finish_up();
    end

    // Every clock: the two pulses never coincide (R10).
    always @(negedge clk) begin
        if (rst_n === 1'b1 && done && fault) begin
            vectors++;
            miscompares++;
            $display("FAIL R10 done and fault together actual=1 expected=0");
        end
    end

    task automatic poke(input logic [31:0] addr, input logic [7:0] val);
        @(negedge clk);
        tb_we = 1'b1; tb_wa = addr[9:0]; tb_wd = val;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic put_desc(input logic [15:0] off, input logic [31:0] base,
                            input logic [19:0] lim, input logic [7:0] acc, input logic [3:0] flg);
        logic [31:0] a;
        a = tbase_m + 32'(off);
        poke(a + 0, lim[7:0]);
        poke(a + 1, lim[15:8]);
        poke(a + 2, base[7:0]);
        poke(a + 3, base[15:8]);
        poke(a + 4, base[23:16]);
        poke(a + 5, acc);
        poke(a + 6, {flg, lim[19:16]});
        poke(a + 7, base[31:24]);
    endtask

    task automatic set_table(input logic [31:0] b, input logic [15:0] s);
        @(negedge clk);
        tbl_wr = 1'b1; tbl_base = b; tbl_size = s;
        @(negedge clk);
        tbl_wr = 1'b0;
        tbase_m = b; tsize_m = s;
    endtask

    task automatic compare_caches(input string tag);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            rd_idx = 3'(i);
            #1;
            check_eq({tag, " R12 sel"},   64'(rd_sel),   64'(e_sel[i]));
            check_eq({tag, " R8 base"},   64'(rd_base),  64'(e_base[i]));
            check_eq({tag, " R8 limit"},  64'(rd_limit), 64'(e_lim[i]));
            check_eq({tag, " R8 attr"},   64'(rd_attr),  64'(e_attr[i]));
        end
    endtask

    task automatic do_load(input logic [15:0] sel, input logic [2:0] idx,
                           input bit tw, input logic [15:0] nsize, input string tag);
        logic [31:0] a;
        logic [7:0]  acc;
        logic [3:0]  flg;
        logic [19:0] lim;
        logic [31:0] base;
        int exp_cause, exp_lat, k, rd0, wr0;
        bit exp_mark, is_code, cls_ok;

        a = tbase_m + 32'(sel);
        acc  = mem[a[9:0] + 10'd5];
        flg  = mem[a[9:0] + 10'd6][7:4];
        lim  = {mem[a[9:0] + 10'd6][3:0], mem[a[9:0] + 10'd1], mem[a[9:0]]};
        base = {mem[a[9:0] + 10'd7], mem[a[9:0] + 10'd4], mem[a[9:0] + 10'd3], mem[a[9:0] + 10'd2]};
        exp_mark = 1'b0;
        is_code  = acc[3];
        cls_ok   = is_code ? (idx == 3'd0) : (idx != 3'd0 && idx <= 3'd5);
        if (sel == 16'h0)                               begin exp_cause = 0; exp_lat = 1; end
        else if (int'(sel) + 7 > int'(tsize_m))         begin exp_cause = 1; exp_lat = 1; end
        else if (!acc[7])                               begin exp_cause = 2; exp_lat = 4; end
        else if (!acc[4] || flg[0] || flg[1])           begin exp_cause = 4; exp_lat = 4; end
        else if (!cls_ok)                               begin exp_cause = 3; exp_lat = 4; end
        else begin
            exp_cause = -1;
            exp_mark  = !acc[0];
            exp_lat   = exp_mark ? 5 : 4;
        end
        rd0 = rd_cnt;
        wr0 = wr_cnt;

        @(negedge clk);
        check_eq({tag, " R11 ready before request"}, 64'(req_ready), 64'd1);
        req_valid = 1'b1; req_sel = sel; req_idx = idx;
        if (tw) begin tbl_wr = 1'b1; tbl_size = nsize; end
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; tbl_wr = 1'b0;
        if (tw) tsize_m = nsize;
        k = 1;
        while (!(done || fault) && k < 200) begin
            check_eq({tag, " R11 ready low while busy"}, 64'(req_ready), 64'd0);
            @(posedge clk);
            @(negedge clk);
            k++;
        end
        check_eq({tag, " R11 ready low in pulse"}, 64'(req_ready), 64'd0);
        if (exp_cause < 0) begin
            check_eq({tag, " R8 done"}, {62'd0, done, fault}, 64'b10);
        end else begin
            check_eq({tag, " R5 R6 R7 fault"}, {62'd0, done, fault}, 64'b01);
            check_eq({tag, " R3 R4 R5 R6 R7 cause"}, 64'(fault_cause), 64'(exp_cause));
        end
        if (!stall_en) check_eq({tag, " R10 latency"}, 64'(k), 64'(exp_lat));

        if (exp_cause == 0 || exp_cause == 1) begin
            check_eq({tag, " R3 R4 no reads"}, 64'(rd_cnt - rd0), 64'd0);
        end else begin
            check_eq({tag, " R2 read count"}, 64'(rd_cnt - rd0), 64'd2);
            check_eq({tag, " R2 low word addr"},  64'(rd_log[rd0 % 4]),       64'(a));
            check_eq({tag, " R2 high word addr"}, 64'(rd_log[(rd0 + 1) % 4]), 64'(a + 32'd4));
        end
        check_eq({tag, " R9 write count"}, 64'(wr_cnt - wr0), exp_mark ? 64'd1 : 64'd0);
        if (exp_mark) begin
            check_eq({tag, " R9 write addr"}, 64'(wr_log), 64'(a + 32'd4));
            check_eq({tag, " R9 access byte"}, 64'(mem[a[9:0] + 10'd5]), 64'(acc | 8'h01));
        end

        if (exp_cause < 0) begin
            e_sel[idx]  = sel;
            e_base[idx] = base;
            e_lim[idx]  = flg[3] ? {lim, 12'hFFF} : {12'h000, lim};
            e_attr[idx] = {flg, acc | 8'h01};
        end
        @(posedge clk);
        @(negedge clk);
        check_eq({tag, " R11 ready after pulse"}, 64'(req_ready), 64'd1);
        compare_caches(tag);
    endtask

    initial begin
        rst_n = 1'b0; tbl_wr = 1'b0; tbl_base = '0; tbl_size = '0;
        req_valid = 1'b0; req_sel = '0; req_idx = '0; rd_idx = '0;
        tb_we = 1'b0; tb_wa = '0; tb_wd = '0;
        tbase_m = '0; tsize_m = '0;
        for (int i = 0; i < 8; i++) begin
            e_sel[i] = '0; e_base[i] = '0; e_lim[i] = '0; e_attr[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1 ready",   64'(req_ready), 64'd1);
        check_eq("R1 pulses",  {62'd0, done, fault}, 64'd0);
        check_eq("R1 mem_req", 64'(mem_req), 64'd0);
        compare_caches("R1 reset");

        set_table(32'h0000_0100, 16'd47);
        put_desc(16'h08, 32'h0000_0000, 20'hFFFFF, 8'h9A, 4'hC);
        put_desc(16'h10, 32'h1234_5678, 20'h0ABCD, 8'h92, 4'h4);
        put_desc(16'h18, 32'hDEAD_0000, 20'h00010, 8'hF3, 4'hC);
        put_desc(16'h20, 32'h0000_1000, 20'h00FFF, 8'h12, 4'h4);
        put_desc(16'h28, 32'h0000_2000, 20'h00FFF, 8'h82, 4'h4);
        put_desc(16'h30, 32'h0000_4000, 20'h00FFF, 8'h92, 4'h4);

        do_load(16'h10, 3'd1, 1'b0, 16'd0, "R8 R9 data into DS");
        do_load(16'h08, 3'd0, 1'b0, 16'd0, "R8 R9 code into CS granular");
        do_load(16'h18, 3'd2, 1'b0, 16'd0, "R9 already accessed");
        do_load(16'h00, 3'd3, 1'b0, 16'd0, "R3 null");
        do_load(16'h08, 3'd1, 1'b0, 16'd0, "R7 code into DS");
        do_load(16'h10, 3'd0, 1'b0, 16'd0, "R7 data into CS");
        do_load(16'h20, 3'd4, 1'b0, 16'd0, "R5 absent");
        do_load(16'h28, 3'd4, 1'b0, 16'd0, "R6 access bit4 clear");
        do_load(16'h30, 3'd5, 1'b0, 16'd0, "R4 beyond table");
        do_load(16'h29, 3'd5, 1'b0, 16'd0, "R4 last byte one past");
        do_load(16'h30, 3'd5, 1'b1, 16'd63, "R4 same-edge table write");
        do_load(16'h30, 3'd5, 1'b0, 16'd0, "R4 after table grow");
        do_load(16'h18, 3'd6, 1'b0, 16'd0, "R7 index six");

        put_desc(16'h30, 32'h0000_4000, 20'h00FFF, 8'h93, 4'h5);
        do_load(16'h30, 3'd5, 1'b0, 16'd0, "R6 flag bit0 set");
        put_desc(16'h38, 32'h0000_5000, 20'h00FFF, 8'h0A, 4'h4);
        do_load(16'h38, 3'd1, 1'b0, 16'd0, "R5 absent beats reserved");
        put_desc(16'h38, 32'h0000_5000, 20'h00FFF, 8'h8A, 4'h4);
        do_load(16'h38, 3'd1, 1'b0, 16'd0, "R6 reserved beats class");

        stall_en = 1'b1;
        do_load(16'h10, 3'd4, 1'b0, 16'd0, "R2 wait states no write");
        put_desc(16'h30, 32'hCAFE_0000, 20'h12345, 8'hF2, 4'h4);
        do_load(16'h30, 3'd3, 1'b0, 16'd0, "R9 wait states with write");
        do_load(16'h20, 3'd3, 1'b0, 16'd0, "R11 fault keeps caches");
        stall_en = 1'b0;

        finish_up();
    end
endmodule